// File: doc/BRIEF.md
# Network Controller Indirect Register Front End

This block is the register interface that a host processor sees on a network controller. A small slave port exposes three locations: an index pointer and two data windows. Each data window reaches its own bank of indexed registers, a status/control bank and a bus-configuration bank. A host selects a register by writing its index to the pointer, then reads or writes it through the data window of the bank it wants.

Most indices are plain storage. A few have their own behaviour. Index 0 of the status/control bank is the main control word. It has a stop command that overrides all others, write-one-to-clear error flags, and receive/transmit interrupt flags that clear only on every third ordinary write. Index 6 holds the two descriptor-ring log2 lengths. Index 88 returns a fixed identity value. In the configuration bank, index 9 is a constant, and index 34 reads the PHY management register chosen by index 33.

The block emits one-cycle request pulses for the initialization fetch, the receive/transmit enable update and the ring-position reset. It takes single-cycle event inputs from the DMA side that raise status flags, and it drives a level interrupt.

Top module: `netctl_regs`

## Requirements
- R1: The port decodes offset 0x14 as the pointer, 0x10 as the status/control window and 0x1C as the configuration window. Any other offset reads 0, and writes to it change nothing. Read data is combinational from `off` and the current state. A write takes effect at the clock edge where `sel` and `wr` are both high.
- R2: A pointer write keeps `wdata[7:0]`, and a read of the pointer returns that value. The pointer selects the index for both windows. It resets to 0.
- R3: A write to control word index 0 with bit 2 (STOP) set leaves the word equal to 0x0004 and pulses `ring_rst` in the next cycle. In that same write, INIT and START give no pulse and `evt_set` is ignored. The word resets to 0x0004.
- R4: A control-word write without STOP clears each of bits 14, 13, 12, 11 and 8 for which the written bit is 1.
- R5: Bits 10 and 9 are cleared by written ones only on the 3rd, 6th, 9th and later multiples of three among the non-STOP writes to the control word since reset. STOP writes do not advance this count.
- R6: Bit 6 (interrupt enable) is set by a non-STOP write with bit 6 at 1. Writing 0 to bit 6 leaves it unchanged.
- R7: A non-STOP write with bit 0 set sets bit 0, clears bit 2 and pulses `init_req` in the next cycle. A non-STOP write with bit 1 set sets bit 1, clears bit 2 and pulses `rxtx_upd` in the next cycle.
- R8: Writing status index 6 stores the receive log2 length from `wdata[11:8]` and the transmit log2 length from `wdata[15:12]`. The two values drive `rx_l2len` and `tx_l2len`. A read of index 6 returns only those two fields, in bits 11:8 and 15:12.
- R9: Status index 88 reads 0x02623003 when `FAST_PHY` is 1 and 0 otherwise. Writes to it change nothing.
- R10: Configuration index 9 always reads 1, and writes to it change nothing. Configuration index 33 is stored, and its bits 9:5 drive `phy_addr` and bits 4:0 drive `phy_reg`. Configuration index 34 reads `phy_rdata` zero-extended. Writes to index 34 change nothing.
- R11: Every other index below `DEPTH` in either bank is a 32-bit read/write register that resets to 0. The two banks are independent. Indices at or above `DEPTH` read 0.
- R12: When no STOP write is taking place, `evt_set[k]` sets control-word bit 8+k at the clock edge, and this takes priority over a clear in the same write. `irq` is high exactly when bit 6 is set and any of bits 14:8 is set.
- R13: A write to status index 15 stores the value and pulses `rxtx_upd` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Access strobe |
| wr | input | 1 | 1 = write, 0 = read |
| off | input | 8 | Byte offset within the port |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the current offset and pointer |
| evt_set | input | 7 | Status event pulses, bit k sets control bit 8+k |
| irq | output | 1 | Interrupt level |
| init_req | output | 1 | Initialization fetch request pulse |
| rxtx_upd | output | 1 | Receive/transmit enable update pulse |
| ring_rst | output | 1 | Ring position reset pulse |
| rx_l2len | output | 4 | Receive ring log2 length |
| tx_l2len | output | 4 | Transmit ring log2 length |
| phy_addr | output | 5 | PHY address for management reads |
| phy_reg | output | 5 | PHY register number for management reads |
| phy_rdata | input | PHY_W | PHY management read data |

## Verification
Most internal state is visible at once. The control word, the pointer and the stored registers can be read back through `rdata` in the cycle after any write, and a corrupted flag shows on `irq` in that same cycle. The third-write counter is the exception: it stays hidden until the next write that would clear bits 10 and 9. A wrong count therefore appears only one to three writes later, as those bits surviving or vanishing in the read-back. The pulse outputs show a wrong decode one cycle after the offending write.

// File: rtl/netctl_regs.sv
module netctl_regs #(
  parameter int DEPTH    = 128,
  parameter int PHY_W    = 16,
  parameter bit FAST_PHY = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             wr,
  input  logic [7:0]       off,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic [6:0]       evt_set,
  output logic             irq,
  output logic             init_req,
  output logic             rxtx_upd,
  output logic             ring_rst,
  output logic [3:0]       rx_l2len,
  output logic [3:0]       tx_l2len,
  output logic [4:0]       phy_addr,
  output logic [4:0]       phy_reg,
  input  logic [PHY_W-1:0] phy_rdata
);
  localparam int IW = $clog2(DEPTH);
  localparam logic [7:0] OFF_PTR = 8'h14;
  localparam logic [7:0] OFF_CSR = 8'h10;
  localparam logic [7:0] OFF_BCR = 8'h1C;
  localparam logic [31:0] CHIP_ID = FAST_PHY ? 32'h0262_3003 : 32'h0;
  localparam logic [15:0] W1C_ERR = 16'h7900;
  localparam logic [15:0] W1C_RTX = 16'h0600;

  logic [7:0]  rap;
  logic [15:0] c0, c0_n, mask;
  logic [1:0]  wcnt, wcnt_n;
  logic [31:0] cmem [DEPTH];
  logic [31:0] bmem [DEPTH];

  wire wr_ptr = sel && wr && (off == OFF_PTR);
  wire wr_csr = sel && wr && (off == OFF_CSR);
  wire wr_bcr = sel && wr && (off == OFF_BCR);
  wire wr0    = wr_csr && (rap == 8'd0);
  wire stop_w = wr0 && wdata[2];
  wire in_rng = int'(rap) < DEPTH;
  wire [IW-1:0] idx = rap[IW-1:0];

  always_comb begin
    c0_n   = c0;
    wcnt_n = wcnt;
    mask   = W1C_ERR;
    if (stop_w) begin
      c0_n = 16'h0004;
    end else begin
      if (wr0) begin
        if (wcnt == 2'd2) begin
          mask   = W1C_ERR | W1C_RTX;
          wcnt_n = 2'd0;
        end else begin
          wcnt_n = wcnt + 2'd1;
        end
        c0_n = (c0 & ~(wdata[15:0] & mask)) | (wdata[15:0] & 16'h0040);
        if (wdata[0]) c0_n = (c0_n | 16'h0001) & ~16'h0004;
        if (wdata[1]) c0_n = (c0_n | 16'h0002) & ~16'h0004;
      end
      c0_n[14:8] = c0_n[14:8] | evt_set;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rap      <= '0;
      c0       <= 16'h0004;
      wcnt     <= '0;
      rx_l2len <= '0;
      tx_l2len <= '0;
      init_req <= 1'b0;
      rxtx_upd <= 1'b0;
      ring_rst <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        cmem[i] <= '0;
        bmem[i] <= '0;
      end
    end else begin
      c0       <= c0_n;
      wcnt     <= wcnt_n;
      init_req <= wr0 && !stop_w && wdata[0];
      rxtx_upd <= (wr0 && !stop_w && wdata[1]) || (wr_csr && rap == 8'd15);
      ring_rst <= stop_w;
      if (wr_ptr) rap <= wdata[7:0];
      if (wr_csr && rap == 8'd6) begin
        rx_l2len <= wdata[11:8];
        tx_l2len <= wdata[15:12];
      end
      if (wr_csr && in_rng && rap != 8'd0 && rap != 8'd6 && rap != 8'd88)
        cmem[idx] <= wdata;
      if (wr_bcr && in_rng && rap != 8'd9 && rap != 8'd34)
        bmem[idx] <= wdata;
    end
  end

  assign phy_addr = bmem[33][9:5];
  assign phy_reg  = bmem[33][4:0];
  assign irq      = c0[6] && (|c0[14:8]);

  always_comb begin
    rdata = '0;
    case (off)
      OFF_PTR: rdata = {24'd0, rap};
      OFF_CSR:
        case (rap)
          8'd0:    rdata = {16'd0, c0};
          8'd6:    rdata = {16'd0, tx_l2len, rx_l2len, 8'd0};
          8'd88:   rdata = CHIP_ID;
          default: rdata = in_rng ? cmem[idx] : '0;
        endcase
      OFF_BCR:
        case (rap)
          8'd9:    rdata = 32'd1;
          8'd34:   rdata = 32'(phy_rdata);
          default: rdata = in_rng ? bmem[idx] : '0;
        endcase
      default: rdata = '0;
    endcase
  end
endmodule

module netctl_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sel,
  input logic        wr,
  input logic [7:0]  off,
  input logic [31:0] wdata,
  input logic [6:0]  evt_set,
  input logic [7:0]  rap,
  input logic [15:0] c0,
  input logic        init_req,
  input logic        rxtx_upd,
  input logic        ring_rst
);
  wire w0 = sel && wr && off == 8'h10 && rap == 8'd0;

  p_stop_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (w0 && wdata[2]) |=> (c0 == 16'h0004 && ring_rst && !init_req && !rxtx_upd));

  p_w1c_babl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (w0 && !wdata[2] && wdata[14] && !evt_set[6]) |=> !c0[14]);

  p_ien_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (w0 && !wdata[2] && wdata[6]) |=> c0[6]);

  p_init_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (w0 && !wdata[2] && wdata[0]) |=> (init_req && c0[0] && !c0[2]));

  p_ptr_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && off == 8'h14) |=> (rap == $past(wdata[7:0])));
endmodule

bind netctl_regs netctl_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .off(off), .wdata(wdata),
  .evt_set(evt_set), .rap(rap), .c0(c0), .init_req(init_req),
  .rxtx_upd(rxtx_upd), .ring_rst(ring_rst)
);

// File: tb/netctl_regs_tb.sv
`timescale 1ns/1ps
module netctl_regs_tb;
  localparam int DEPTH = 128;
  localparam logic [31:0] ID = 32'h0262_3003;

  logic clk = 0, rst_n = 0, sel = 0, wr = 0;
  logic [7:0] off = 0;
  logic [31:0] wdata = 0, rdata;
  logic [6:0] evt_set = 0;
  logic irq, init_req, rxtx_upd, ring_rst;
  logic [3:0] rx_l2len, tx_l2len;
  logic [4:0] phy_addr, phy_reg;
  logic [15:0] phy_rdata;

  always #5 clk = ~clk;
  assign phy_rdata = {1'b1, phy_addr, phy_reg, phy_reg ^ 5'h15};

  netctl_regs #(.DEPTH(DEPTH), .PHY_W(16), .FAST_PHY(1'b1)) u_dut (.*);

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [7:0]  m_rap = 0;
  logic [15:0] m_c0 = 16'h0004;
  int          m_cnt = 0;
  logic [3:0]  m_rx = 0, m_tx = 0;
  logic [31:0] m_cmem [int];
  logic [31:0] m_bmem [int];
  bit m_init = 0, m_upd = 0, m_ring = 0;

  function automatic logic [31:0] cget(int i);
    return m_cmem.exists(i) ? m_cmem[i] : 32'd0;
  endfunction
  function automatic logic [31:0] bget(int i);
    return m_bmem.exists(i) ? m_bmem[i] : 32'd0;
  endfunction

  function automatic logic [31:0] m_read();
    int r = int'(m_rap);
    logic [31:0] b33 = bget(33);
    case (off)
      8'h14: return {24'd0, m_rap};
      8'h10:
        if (r == 0) return {16'd0, m_c0};
        else if (r == 6) return {16'd0, m_tx, m_rx, 8'd0};
        else if (r == 88) return ID;
        else return (r < DEPTH) ? cget(r) : 32'd0;
      8'h1C:
        if (r == 9) return 32'd1;
        else if (r == 34) return {16'd0, 1'b1, b33[9:5], b33[4:0], b33[4:0] ^ 5'h15};
        else return (r < DEPTH) ? bget(r) : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  task automatic cmp(string tag, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic m_update();
    int r = int'(m_rap);
    bit sw = sel && wr && off == 8'h10 && r == 0 && wdata[2];
    logic [15:0] mk;
    m_init = 0; m_upd = 0; m_ring = 0;
    if (sw) begin
      m_c0 = 16'h0004;
      m_ring = 1;
    end else begin
      if (sel && wr && off == 8'h10 && r == 0) begin
        m_cnt++;
        mk = 16'h7900;
        if (m_cnt == 3) begin mk |= 16'h0600; m_cnt = 0; end
        m_c0 = m_c0 & ~(wdata[15:0] & mk);
        m_c0 |= wdata[15:0] & 16'h0040;
        if (wdata[0]) begin m_c0 |= 16'h0001; m_c0 &= ~16'h0004; m_init = 1; end
        if (wdata[1]) begin m_c0 |= 16'h0002; m_c0 &= ~16'h0004; m_upd = 1; end
      end
      m_c0[14:8] = m_c0[14:8] | evt_set;
    end
    if (sel && wr) begin
      if (off == 8'h14) m_rap = wdata[7:0];
      else if (off == 8'h10) begin
        if (r == 6) begin m_rx = wdata[11:8]; m_tx = wdata[15:12]; end
        else if (r == 15) begin m_cmem[r] = wdata; m_upd = 1; end
        else if (r != 0 && r != 88 && r < DEPTH) m_cmem[r] = wdata;
      end else if (off == 8'h1C) begin
        if (r != 9 && r != 34 && r < DEPTH) m_bmem[r] = wdata;
      end
    end
  endtask

  task automatic step(string tag, bit s, bit w, logic [7:0] o, logic [31:0] d,
                      logic [6:0] ev = 7'd0);
    logic [31:0] b33;
    @(negedge clk);
    sel = s; wr = w; off = o; wdata = d; evt_set = ev;
    #4;
    b33 = bget(33);
    cmp(tag, rdata, m_read());
    cmp("R12 irq", {31'd0, irq}, {31'd0, m_c0[6] && (|m_c0[14:8])});
    cmp("R7 init_req", {31'd0, init_req}, {31'd0, m_init});
    cmp("R13 rxtx_upd", {31'd0, rxtx_upd}, {31'd0, m_upd});
    cmp("R3 ring_rst", {31'd0, ring_rst}, {31'd0, m_ring});
    cmp("R8 l2len", {24'd0, tx_l2len, rx_l2len}, {24'd0, m_tx, m_rx});
    cmp("R10 phy sel", {22'd0, phy_addr, phy_reg}, {22'd0, b33[9:5], b33[4:0]});
    @(posedge clk);
    m_update();
  endtask

  task automatic wr_(string tag, logic [7:0] o, logic [31:0] d, logic [6:0] ev = 7'd0);
    step(tag, 1, 1, o, d, ev);
  endtask
  task automatic rd_(string tag, logic [7:0] o);
    step(tag, 1, 0, o, 32'd0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // reset state
    rd_("R2 reset ptr", 8'h14);
    rd_("R3 reset word", 8'h10);
    // pointer
    wr_("R2 ptr write", 8'h14, 32'h0000_01A5);
    rd_("R2 ptr low byte", 8'h14);
    wr_("R2 ptr zero", 8'h14, 32'd0);
    // events and irq
    step("R12 events", 0, 0, 8'h10, 32'd0, 7'h7F);
    rd_("R12 flags set", 8'h10);
    wr_("R4 clear babl", 8'h10, 32'h0000_4000);
    rd_("R4 read", 8'h10);
    wr_("R5 second write keeps rint", 8'h10, 32'h0000_0600);
    rd_("R5 read2", 8'h10);
    wr_("R5 third write clears", 8'h10, 32'h0000_0600);
    rd_("R5 read3", 8'h10);
    wr_("R6 set ien", 8'h10, 32'h0000_0040);
    rd_("R6 ien irq", 8'h10);
    wr_("R6 zero keeps", 8'h10, 32'h0000_0000);
    wr_("R4 clear rest", 8'h10, 32'h0000_3900);
    rd_("R12 irq off", 8'h10);
    wr_("R12 evt beats clear", 8'h10, 32'h0000_0100, 7'h01);
    rd_("R12 evt read", 8'h10);
    wr_("R7 init", 8'h10, 32'h0000_0001);
    wr_("R7 start", 8'h10, 32'h0000_0002);
    rd_("R7 read", 8'h10);
    wr_("R3 stop wins", 8'h10, 32'h0000_0007, 7'h7F);
    rd_("R3 read", 8'h10);
    // ring lengths
    wr_("R8 ptr", 8'h14, 32'd6);
    wr_("R8 write", 8'h10, 32'hFFFF_A5FF);
    rd_("R8 read", 8'h10);
    wr_("R9 ptr", 8'h14, 32'd88);
    wr_("R9 write", 8'h10, 32'h1234_5678);
    rd_("R9 id", 8'h10);
    // configuration bank
    wr_("R10 ptr9", 8'h14, 32'd9);
    wr_("R10 write9", 8'h1C, 32'h0);
    rd_("R10 read9", 8'h1C);
    wr_("R10 ptr33", 8'h14, 32'd33);
    wr_("R10 sel", 8'h1C, {22'd0, 5'd19, 5'd7});
    wr_("R10 ptr34", 8'h14, 32'd34);
    rd_("R10 phy read", 8'h1C);
    wr_("R10 write34", 8'h1C, 32'hFFFF_FFFF);
    rd_("R10 phy read2", 8'h1C);
    // storage
    wr_("R11 ptr20", 8'h14, 32'd20);
    wr_("R11 csr20", 8'h10, 32'hDEAD_BEEF);
    wr_("R11 bcr20", 8'h1C, 32'h0BAD_F00D);
    rd_("R11 csr20 read", 8'h10);
    rd_("R11 bcr20 read", 8'h1C);
    wr_("R11 ptr200", 8'h14, 32'd200);
    wr_("R11 high write", 8'h10, 32'h5555_5555);
    rd_("R11 high read", 8'h10);
    wr_("R1 bad offset", 8'h18, 32'hFFFF_FFFF);
    rd_("R1 bad read", 8'h18);
    rd_("R1 ptr intact", 8'h14);
    wr_("R13 ptr15", 8'h14, 32'd15);
    wr_("R13 write15", 8'h10, 32'h0000_1234);
    rd_("R13 read15", 8'h10);
    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      int k = $urandom_range(0, 9);
      logic [7:0] o;
      logic [31:0] d = $urandom;
      logic [6:0] ev = ($urandom_range(0, 3) == 0) ? 7'($urandom) : 7'd0;
      case ($urandom_range(0, 3))
        0: o = 8'h14;
        1: o = 8'h10;
        2: o = 8'h1C;
        default: o = 8'h18;
      endcase
      if (o == 8'h14) begin
        case (k)
          0: d = 0; 1: d = 6; 2: d = 9; 3: d = 15; 4: d = 33;
          5: d = 34; 6: d = 88; 7: d = 20; 8: d = 200; default: d = 0;
        endcase
      end
      step("R11 mixed", $urandom_range(0, 4) != 0, $urandom_range(0, 1) == 1, o, d, ev);
    end
    done = 1;
    finish_run();
  end
endmodule